// File: doc/BRIEF.md
# Anti-windup PID controller datapath

This block is a sampled, fixed-point PID controller. Each time the sample strobe is high for a clock cycle, it takes a reference, a feedback value and an external "loop is healthy" flag. One clock cycle later it presents a clamped control output, a one-cycle valid pulse and a saturation status bit. Gains, derivative-filter coefficients and the two clamp limits are held at its inputs by surrounding registers. A mode input selects between two gain arrangements. In the parallel arrangement each path carries its own gain. In the ideal arrangement the proportional gain scales the sum of all three paths.

The proportional path weights the reference on its own before subtracting the feedback. The integral path adds the scaled error once per sample. It is frozen when the previous sample was clipped at the output clamp, and also when the external flag reports saturation elsewhere in the loop. Holding the external flag at 1 disables that feature. The integral gain is applied exactly as loaded, so the caller folds the sample period into it. The derivative path is a first-order lag with a differentiator, discretised with the bilinear (Tustin) rule. Its two stored states are the previous error and the previous filter output.

All values are signed two's complement with FRAC fractional bits. With the defaults (DW=16, FRAC=12), 4096 represents 1.0. Every product is shifted right arithmetically by FRAC, which rounds toward minus infinity. Every sum and product then saturates to the DW-bit range.

Top module: `pid_awu`

## Requirements
- R1: A synchronous reset (rst=1 at a clock edge) clears the output to 0, the valid pulse to 0, the status bit to 0, the integrator state and both derivative states to 0, and opens the integrator gate (gate=1).
- R2: u_valid is 1 in exactly the cycle after a cycle with strobe=1 and 0 otherwise. u_out and sat_out change only in that cycle and hold their value between samples.
- R3: The proportional input is p = sat(mul(ref_wt, ref_in) - fbk_in), where mul(a,b) = sat((a*b) >>> FRAC) and sat() limits to the signed DW-bit range. The error is e = sat(ref_in - fbk_in).
- R4: On each sample with the gate open, the integrator becomes i = sat(i_prev + mul(ki, e)). The new value is used in that same sample's output, and the integrator does not change between samples.
- R5: A sample whose output was clipped closes the internal gate for the next sample, so mul(ki, e) is replaced by 0. The gate reopens after the first sample that is not clipped.
- R6: A sample taken with ext_ok=0 adds nothing to the integrator, whatever the state of the internal gate.
- R7: The derivative term is dterm = mul(kd, f), where f = sat(mul(flt_c1, sat(e - e_prev)) + mul(flt_c2, f_prev)).
- R8: e_prev and f_prev are the error and the filter output of the previous sample. Both are 0 for the first sample after reset.
- R9: With mode_ideal=0 the sum is sat(sat(mul(kp,p) + i) + dterm). With mode_ideal=1 it is mul(kp, sat(sat(p + i) + dterm)).
- R10: The output is lim_hi if the sum is strictly greater than lim_hi, otherwise lim_lo if the sum is strictly below lim_lo, otherwise the sum itself. sat_out is 1 exactly when one of the first two cases applies. A sum equal to a limit is not clipped.
- R11: Every intermediate value saturates at the signed DW-bit bounds instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Sample strobe, one cycle per sample |
| mode_ideal | input | 1 | 0 = parallel gains, 1 = ideal (series) gains |
| ext_ok | input | 1 | External saturation flag: 1 normal, 0 saturated |
| ref_in | input | DW | Reference value |
| fbk_in | input | DW | Feedback value |
| ref_wt | input | DW | Reference weight for the proportional path |
| kp | input | DW | Proportional gain |
| ki | input | DW | Integral gain, already scaled by the sample period |
| kd | input | DW | Derivative gain |
| flt_c1 | input | DW | Derivative filter input coefficient |
| flt_c2 | input | DW | Derivative filter feedback coefficient |
| lim_hi | input | DW | Upper clamp limit |
| lim_lo | input | DW | Lower clamp limit |
| u_out | output | DW | Clamped control output |
| u_valid | output | 1 | One-cycle pulse marking a new output |
| sat_out | output | 1 | Set when the output was clipped |

## Verification
The bench targets the following corner cases:

- **Limit handling.** It drives sums onto, just past and just short of each limit. A clamp using >= would flag sums that sit exactly on a limit, and one that tested the lower limit first would return the wrong limit when the limits cross.
- **Gate timing.** It drives the integrator into clipping and then reverses the error. A gate applied in the same sample, or never reopened, shows up as an output sequence that drifts away from the model.
- **External flag.** It exercises the external flag with the other gains at zero, so a missing gate appears directly as a moving output.
- **Derivative state.** The derivative sweep starts right after reset. Filter states updated before use, or not cleared, change the very first samples.
- **Saturation and mode.** Long integration runs and full-range pseudo-random sweeps in both modes expose wrap-around where saturation was expected, and a swapped ideal/parallel arrangement.

// File: rtl/pid_awu_pkg.sv
package pid_awu_pkg;

    typedef logic signed [63:0] wide_t;

    typedef enum logic {
        PID_PARALLEL = 1'b0,
        PID_IDEAL    = 1'b1
    } pid_form_e;

    // Limit a wide value to the signed range of dw bits.
    function automatic wide_t sat_to(input wide_t x, input int unsigned dw);
        wide_t top;
        wide_t bot;
        top = (wide_t'(1) <<< (dw - 1)) - wide_t'(1);
        bot = -(wide_t'(1) <<< (dw - 1));
        if (x > top)
            return top;
        else if (x < bot)
            return bot;
        else
            return x;
    endfunction

    // Fixed-point product: floor shift by frac, then saturate to dw bits.
    function automatic wide_t qmul(input wide_t a, input wide_t b,
                                   input int unsigned frac, input int unsigned dw);
        return sat_to((a * b) >>> frac, dw);
    endfunction

endpackage

// File: rtl/pid_awu_integ.sv
module pid_awu_integ
    import pid_awu_pkg::*;
#(
    parameter int unsigned DW   = 16,
    parameter int unsigned FRAC = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic                 ext_ok,
    input  logic                 clip_now,
    input  logic signed [DW-1:0] ki,
    input  logic signed [DW-1:0] err,
    output logic signed [DW-1:0] acc_next,
    output logic signed [DW-1:0] acc_state,
    output logic                 gate_state
);

    typedef struct packed {
        logic signed [DW-1:0] acc;
        logic                 gate;
    } integ_st_t;

    integ_st_t st_d, st_q;

    function automatic logic signed [DW-1:0] fit(input wide_t x);
        wide_t t;
        t = sat_to(x, DW);
        return t[DW-1:0];
    endfunction

    logic  open_gate;
    wide_t incr;

    // Candidate accumulator value for this sample; independent of clip_now.
    always_comb begin
        open_gate = st_q.gate & ext_ok;
        incr      = open_gate ? qmul(wide_t'(ki), wide_t'(err), FRAC, DW) : wide_t'(0);
        acc_next  = fit(wide_t'(st_q.acc) + incr);
    end

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.acc  = acc_next;
            st_d.gate = ~clip_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc  <= '0;
            st_q.gate <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_state  = st_q.acc;
    assign gate_state = st_q.gate;

endmodule

// File: rtl/pid_awu_deriv.sv
module pid_awu_deriv
    import pid_awu_pkg::*;
#(
    parameter int unsigned DW   = 16,
    parameter int unsigned FRAC = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic signed [DW-1:0] err,
    input  logic signed [DW-1:0] kd,
    input  logic signed [DW-1:0] c1,
    input  logic signed [DW-1:0] c2,
    output logic signed [DW-1:0] d_term
);

    typedef struct packed {
        logic signed [DW-1:0] e_prev;
        logic signed [DW-1:0] f_prev;
    } deriv_st_t;

    deriv_st_t st_d, st_q;

    function automatic logic signed [DW-1:0] fit(input wide_t x);
        wide_t t;
        t = sat_to(x, DW);
        return t[DW-1:0];
    endfunction

    logic signed [DW-1:0] delta;
    logic signed [DW-1:0] filt;

    // Output is formed from the stored states first; states move afterwards.
    always_comb begin
        delta  = fit(wide_t'(err) - wide_t'(st_q.e_prev));
        filt   = fit(qmul(wide_t'(c1), wide_t'(delta), FRAC, DW)
                   + qmul(wide_t'(c2), wide_t'(st_q.f_prev), FRAC, DW));
        d_term = fit(qmul(wide_t'(kd), wide_t'(filt), FRAC, DW));
        st_d   = st_q;
        if (step) begin
            st_d.e_prev = err;
            st_d.f_prev = filt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pid_awu_clamp.sv
module pid_awu_clamp #(
    parameter int unsigned DW = 16
) (
    input  logic signed [DW-1:0] sum_in,
    input  logic signed [DW-1:0] hi,
    input  logic signed [DW-1:0] lo,
    output logic signed [DW-1:0] lim_out,
    output logic                 clipped
);

    // Upper limit is tested first, so it wins if the limits cross.
    always_comb begin
        if (sum_in > hi) begin
            lim_out = hi;
            clipped = 1'b1;
        end else if (sum_in < lo) begin
            lim_out = lo;
            clipped = 1'b1;
        end else begin
            lim_out = sum_in;
            clipped = 1'b0;
        end
    end

endmodule

// File: rtl/pid_awu.sv
module pid_awu
    import pid_awu_pkg::*;
#(
    parameter int unsigned DW   = 16,
    parameter int unsigned FRAC = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic                 mode_ideal,
    input  logic                 ext_ok,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] fbk_in,
    input  logic signed [DW-1:0] ref_wt,
    input  logic signed [DW-1:0] kp,
    input  logic signed [DW-1:0] ki,
    input  logic signed [DW-1:0] kd,
    input  logic signed [DW-1:0] flt_c1,
    input  logic signed [DW-1:0] flt_c2,
    input  logic signed [DW-1:0] lim_hi,
    input  logic signed [DW-1:0] lim_lo,
    output logic signed [DW-1:0] u_out,
    output logic                 u_valid,
    output logic                 sat_out
);

    typedef struct packed {
        logic signed [DW-1:0] u;
        logic                 valid;
        logic                 sat;
    } out_st_t;

    out_st_t o_d, o_q;

    function automatic logic signed [DW-1:0] fit(input wide_t x);
        wide_t t;
        t = sat_to(x, DW);
        return t[DW-1:0];
    endfunction

    pid_form_e            form;
    logic signed [DW-1:0] err;
    logic signed [DW-1:0] p_in;
    logic signed [DW-1:0] p_term;
    logic signed [DW-1:0] inner;
    logic signed [DW-1:0] total;
    logic signed [DW-1:0] i_next;
    logic signed [DW-1:0] i_state;
    logic                 gate_state;
    logic signed [DW-1:0] d_term;
    logic signed [DW-1:0] u_lim;
    logic                 clip;

    assign form = pid_form_e'(mode_ideal);

    pid_awu_integ #(.DW(DW), .FRAC(FRAC)) u_integ (
        .clk        (clk),
        .rst        (rst),
        .step       (strobe),
        .ext_ok     (ext_ok),
        .clip_now   (clip),
        .ki         (ki),
        .err        (err),
        .acc_next   (i_next),
        .acc_state  (i_state),
        .gate_state (gate_state)
    );

    pid_awu_deriv #(.DW(DW), .FRAC(FRAC)) u_deriv (
        .clk    (clk),
        .rst    (rst),
        .step   (strobe),
        .err    (err),
        .kd     (kd),
        .c1     (flt_c1),
        .c2     (flt_c2),
        .d_term (d_term)
    );

    pid_awu_clamp #(.DW(DW)) u_clamp (
        .sum_in  (total),
        .hi      (lim_hi),
        .lo      (lim_lo),
        .lim_out (u_lim),
        .clipped (clip)
    );

    // Error and proportional input, then the mode-dependent summing point.
    always_comb begin
        err  = fit(wide_t'(ref_in) - wide_t'(fbk_in));
        p_in = fit(qmul(wide_t'(ref_wt), wide_t'(ref_in), FRAC, DW) - wide_t'(fbk_in));
        if (form == PID_IDEAL) begin
            p_term = p_in;
            inner  = fit(wide_t'(fit(wide_t'(p_term) + wide_t'(i_next))) + wide_t'(d_term));
            total  = fit(qmul(wide_t'(kp), wide_t'(inner), FRAC, DW));
        end else begin
            p_term = fit(qmul(wide_t'(kp), wide_t'(p_in), FRAC, DW));
            inner  = fit(wide_t'(p_term) + wide_t'(i_next));
            total  = fit(wide_t'(inner) + wide_t'(d_term));
        end
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = strobe;
        if (strobe) begin
            o_d.u   = u_lim;
            o_d.sat = clip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign u_out   = o_q.u;
    assign u_valid = o_q.valid;
    assign sat_out = o_q.sat;

endmodule

// File: rtl/pid_awu_chk.sv
module pid_awu_chk #(
    parameter int unsigned DW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 strobe,
    input logic                 ext_ok,
    input logic signed [DW-1:0] lim_hi,
    input logic signed [DW-1:0] lim_lo,
    input logic signed [DW-1:0] u_out,
    input logic                 u_valid,
    input logic                 sat_out,
    input logic signed [DW-1:0] i_state,
    input logic                 gate_state
);

    // R1: the cycle after a reset edge shows the cleared state
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!u_valid && u_out == '0 && !sat_out && i_state == '0 && gate_state));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        strobe |=> u_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> !u_valid);

    assert_output_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(u_out) && $stable(sat_out)));

    assert_integ_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(i_state));

    assert_gate_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe && !gate_state) |=> $stable(i_state));

    assert_gate_follows_clip_R5: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (gate_state == !sat_out));

    assert_ext_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (strobe && !ext_ok) |=> $stable(i_state));

    assert_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        (strobe && lim_lo <= lim_hi) |=> (u_out <= $past(lim_hi) && u_out >= $past(lim_lo)));

    assert_sat_at_limit_R10: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (!sat_out || u_out == $past(lim_hi) || u_out == $past(lim_lo)));

endmodule

bind pid_awu pid_awu_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .ext_ok     (ext_ok),
    .lim_hi     (lim_hi),
    .lim_lo     (lim_lo),
    .u_out      (u_out),
    .u_valid    (u_valid),
    .sat_out    (sat_out),
    .i_state    (i_state),
    .gate_state (gate_state)
);

// File: tb/pid_awu_test.sv
module pid_awu_test;

    localparam int DW   = 16;
    localparam int FRAC = 12;
    localparam longint VMAX = (64'sd1 <<< (DW - 1)) - 1;
    localparam longint VMIN = -(64'sd1 <<< (DW - 1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 strobe = 1'b0;
    logic                 mode_ideal = 1'b0;
    logic                 ext_ok = 1'b1;
    logic signed [DW-1:0] ref_in = '0, fbk_in = '0, ref_wt = '0;
    logic signed [DW-1:0] kp = '0, ki = '0, kd = '0, flt_c1 = '0, flt_c2 = '0;
    logic signed [DW-1:0] lim_hi = 16'sh7fff, lim_lo = 16'sh8000;
    logic signed [DW-1:0] u_out;
    logic                 u_valid;
    logic                 sat_out;

    pid_awu #(.DW(DW), .FRAC(FRAC)) uut (
        .clk(clk), .rst(rst), .strobe(strobe), .mode_ideal(mode_ideal), .ext_ok(ext_ok),
        .ref_in(ref_in), .fbk_in(fbk_in), .ref_wt(ref_wt), .kp(kp), .ki(ki), .kd(kd),
        .flt_c1(flt_c1), .flt_c2(flt_c2), .lim_hi(lim_hi), .lim_lo(lim_lo),
        .u_out(u_out), .u_valid(u_valid), .sat_out(sat_out)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    longint m_i, m_ep, m_fp;
    bit     m_gate;
    logic [31:0] lf = 32'h1234_5678;

    function automatic longint bsat(input longint x);
        if (x > VMAX) return VMAX;
        if (x < VMIN) return VMIN;
        return x;
    endfunction

    function automatic longint bmul(input longint a, input longint b);
        return bsat((a * b) >>> FRAC);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_i = 0; m_ep = 0; m_fp = 0; m_gate = 1'b1;
    endtask

    // Expected output of one sample from the current inputs; advances the model.
    task automatic model_step(output longint eu, output bit es);
        longint r, y, e, p, ni, dl, f, dt, s;
        r  = longint'(ref_in);
        y  = longint'(fbk_in);
        e  = bsat(r - y);
        p  = bsat(bmul(longint'(ref_wt), r) - y);
        ni = bsat(m_i + ((m_gate && ext_ok) ? bmul(longint'(ki), e) : 0));
        dl = bsat(e - m_ep);
        f  = bsat(bmul(longint'(flt_c1), dl) + bmul(longint'(flt_c2), m_fp));
        dt = bmul(longint'(kd), f);
        if (mode_ideal)
            s = bmul(longint'(kp), bsat(bsat(p + ni) + dt));
        else
            s = bsat(bsat(bmul(longint'(kp), p) + ni) + dt);
        if (s > longint'(lim_hi)) begin eu = longint'(lim_hi); es = 1'b1; end
        else if (s < longint'(lim_lo)) begin eu = longint'(lim_lo); es = 1'b1; end
        else begin eu = s; es = 1'b0; end
        m_i = ni; m_ep = e; m_fp = f; m_gate = !es;
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic do_sample(input string tag);
        longint eu;
        bit es;
        model_step(eu, es);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check({tag, " u_out"}, longint'(u_out), eu);
        check({tag, " sat_out"}, longint'(sat_out), longint'(es));
        check("R2 valid pulse", longint'(u_valid), 1);
    endtask

    task automatic idle_check();
        longint held;
        held = longint'(u_out);
        @(negedge clk);
        check("R2 valid low between samples", longint'(u_valid), 0);
        check("R2 output held", longint'(u_out), held);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1 reset u_out", longint'(u_out), 0);
        check("R1 reset u_valid", longint'(u_valid), 0);
        check("R1 reset sat_out", longint'(sat_out), 0);
    endtask

    task automatic gains(input int g_kp, input int g_ki, input int g_kd, input int g_wr,
                         input int g_c1, input int g_c2);
        kp = DW'(g_kp); ki = DW'(g_ki); kd = DW'(g_kd); ref_wt = DW'(g_wr);
        flt_c1 = DW'(g_c1); flt_c2 = DW'(g_c2);
    endtask

    function automatic logic [31:0] lf_next(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 initial u_out", longint'(u_out), 0);
        check("R1 initial u_valid", longint'(u_valid), 0);
        check("R1 initial sat_out", longint'(sat_out), 0);

        // Proportional path with reference weighting, both modes (R3, R9)
        for (int md = 0; md < 2; md++) begin
            mode_ideal = md[0];
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 3; b++) begin
                    gains((a == 0) ? 4096 : (a == 1) ? 2048 : -4096, 0, 0,
                          (b == 0) ? 4096 : (b == 1) ? 2048 : 0, 0, 0);
                    for (int ri = -2; ri <= 2; ri++) begin
                        for (int yi = -2; yi <= 2; yi++) begin
                            ref_in = DW'(ri * 1500);
                            fbk_in = DW'(yi * 1500);
                            do_sample(md == 0 ? "R3 proportional" : "R9 ideal proportional");
                        end
                    end
                end
            end
        end
        idle_check();

        // Integral ramp up to saturation (R4, R11)
        mode_ideal = 1'b0;
        do_reset();
        gains(0, 1024, 0, 4096, 0, 0);
        ref_in = 16'sd800;
        fbk_in = 16'sd0;
        for (int k = 0; k < 180; k++) do_sample(k < 150 ? "R4 integrate" : "R11 saturated sum");
        idle_check();
        ref_in = -16'sd800;
        for (int k = 0; k < 10; k++) do_sample("R4 integrate down");

        // Clamp, gate closing and reopening (R5, R10)
        do_reset();
        gains(4096, 2048, 0, 4096, 0, 0);
        lim_hi = 16'sd5000;
        lim_lo = -16'sd5000;
        ref_in = 16'sd3000;
        for (int k = 0; k < 12; k++) do_sample("R5 clipped high");
        ref_in = -16'sd3000;
        for (int k = 0; k < 12; k++) do_sample("R5 recovery");
        mode_ideal = 1'b1;
        ref_in = 16'sd3000;
        for (int k = 0; k < 12; k++) do_sample("R5 ideal clipping");
        mode_ideal = 1'b0;

        // Limit boundaries (R10)
        do_reset();
        gains(4096, 0, 0, 4096, 0, 0);
        ref_in = 16'sd1000;
        fbk_in = 16'sd0;
        lim_hi = 16'sd1000; lim_lo = -16'sd1000;
        do_sample("R10 sum equal to upper limit");
        check("R10 equal not clipped", longint'(sat_out), 0);
        lim_hi = 16'sd999;
        do_sample("R10 one above upper limit");
        check("R10 above clipped", longint'(sat_out), 1);
        lim_hi = 16'sd2000; lim_lo = 16'sd1001;
        do_sample("R10 below lower limit");
        check("R10 lower limit value", longint'(u_out), 1001);
        lim_lo = 16'sd1000;
        do_sample("R10 sum equal to lower limit");
        lim_hi = 16'sd500; lim_lo = 16'sd800;
        do_sample("R10 crossed limits upper wins");
        check("R10 crossed limits value", longint'(u_out), 500);
        lim_hi = 16'sh7fff; lim_lo = 16'sh8000;

        // External saturation flag (R6)
        do_reset();
        gains(0, 4096, 0, 4096, 0, 0);
        ref_in = 16'sd100;
        do_sample("R6 first step");
        check("R6 first step value", longint'(u_out), 100);
        ext_ok = 1'b0;
        do_sample("R6 blocked step");
        check("R6 blocked step value", longint'(u_out), 100);
        do_sample("R6 blocked again");
        ext_ok = 1'b1;
        do_sample("R6 resumed step");
        check("R6 resumed step value", longint'(u_out), 200);

        // Derivative filter from reset (R7, R8)
        do_reset();
        gains(0, 0, 4096, 4096, 3000, 2000);
        ref_in = 16'sd1200;
        do_sample("R8 first derivative sample");
        check("R8 first derivative value", longint'(u_out), (3000 * 1200) >>> FRAC);
        for (int k = 0; k < 40; k++) begin
            ref_in = DW'(((k * 1237) % 4000) - 2000);
            fbk_in = DW'(((k * 611) % 1000) - 500);
            do_sample("R7 derivative sweep");
        end
        mode_ideal = 1'b1;
        gains(2048, 300, 8192, 4096, 3000, -1500);
        for (int k = 0; k < 20; k++) begin
            ref_in = DW'(((k * 977) % 3000) - 1500);
            do_sample("R9 ideal with derivative");
        end

        // Full-range pseudo-random mix (R9, R11, R5, R6)
        do_reset();
        for (int k = 0; k < 2000; k++) begin
            logic signed [DW-1:0] la, lb;
            lf = lf_next(lf); ref_in = lf[15:0]; fbk_in = lf[31:16];
            lf = lf_next(lf); kp = $signed(lf[15:0]) >>> lf[18:16]; ki = $signed(lf[31:16]) >>> lf[21:19];
            lf = lf_next(lf); kd = $signed(lf[15:0]) >>> lf[18:16]; ref_wt = lf[31:16];
            lf = lf_next(lf); flt_c1 = lf[15:0]; flt_c2 = $signed(lf[31:16]) >>> 1;
            lf = lf_next(lf); la = lf[15:0]; lb = lf[31:16];
            lim_hi = (la > lb) ? la : lb;
            lim_lo = (la > lb) ? lb : la;
            lf = lf_next(lf); mode_ideal = lf[0]; ext_ok = lf[1] | lf[2];
            do_sample(mode_ideal ? "R9 random ideal" : "R11 random parallel");
        end
        ext_ok = 1'b1;

        // Reset in mid-run clears the states (R1)
        gains(0, 4096, 4096, 4096, 4096, 0);
        lim_hi = 16'sh7fff; lim_lo = 16'sh8000;
        mode_ideal = 1'b0;
        ref_in = 16'sd300; fbk_in = 16'sd0;
        do_sample("R1 before reset");
        do_reset();
        do_sample("R1 states cleared");
        check("R1 cleared integrator and derivative", longint'(u_out), 600);

        finish_up();
    end

endmodule